// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives a processor core ten 48-bit event counters behind a small register interface. Counter 0 counts every clock cycle and counter 1 counts retired-instruction pulses. Neither of these two has an event selection. Counters 2 to 9 each take an 8-bit event code and count pulses on the matching line of a 256-line event bus. Every counter has its own enable. It also has two privilege qualifiers, one for user level and one for kernel level, and the qualifier that matches the current privilege input decides whether the counter counts.

When an increment moves a counter's top bit from 0 to 1, the counter's bit in a sticky overflow status register is set. An interrupt request is raised when three things hold: the global interrupt mode is not off, some counter has an overflow pending, and that same counter has its interrupt enable set. The request is held in an active flag. Any write to the control register clears the flag. If no enabled overflow remains pending, the request therefore drops. Software reads and writes every register, and every counter, through a single-cycle write port and a combinational read port.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every register (addresses 0 to 4) and every counter (addresses 8 to 17) reads zero, and `irq_o` is low.
- R2: Counter 0 adds one on every clock edge at which it is enabled and qualified. Counter 1 adds one for each cycle in which `instr_ret` is high while it is enabled and qualified.
- R3: A counter n in the range 2 to 9 counts cycles in which `ev_pulse[code]` is high. For n = 2 to 5, the code is byte n-2 of the event-select register at address 2. For n = 6 to 9, it is byte n-6 of the register at address 3. Pulses on other lines are not counted.
- R4: The filter register is at address 1. The user qualifier of counter n is bit n for n < 8 and bit 8+n for n = 8 or 9. The kernel qualifier is bit 8+n for n < 8 and bit 10+n for n = 8 or 9. A counter counts only when the qualifier for the level on `priv_kernel` (1 = kernel) is set.
- R5: The count enable of counter n is control-register bit n for n < 8 and bit 24+n for n = 8 or 9. While that bit is clear, the counter holds its value.
- R6: A write to address 8+n loads counter n on that clock edge, and it wins over an increment in the same cycle. The counter is read back at the same address.
- R7: A counter is 48 bits wide and wraps from 0xFFFF_FFFF_FFFF to 0. A wrap does not set an overflow status bit.
- R8: An increment that changes bit 47 of counter n from 0 to 1 sets bit n of the overflow status register (address 4) on the same edge. The bit then stays set.
- R9: Writing 1 to a bit of the status register clears it. Writing 0 to a bit leaves it unchanged.
- R10: The interrupt mode is control bits [10:8], and 0 means off. The interrupt enable of counter n is bit 12+n for n < 8 and bit 36+n for n = 8 or 9. When the mode is nonzero and some counter has both its status bit and its interrupt enable set, the active flag (control bit 11, read-only) and `irq_o` rise on the next clock edge.
- R11: Any write to the control register clears the active flag on that edge. If no enabled overflow is pending, `irq_o` stays low. If one is pending, the flag sets again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_pulse | input | 256 | One pulse line per event code |
| instr_ret | input | 1 | Retired-instruction pulse |
| priv_kernel | input | 1 | Current privilege level: 1 is kernel, 0 is user |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 64 | Combinational read data |
| irq_o | output | 1 | Interrupt request (active flag) |

## Verification
A register or counter write is visible on `rd_data` right after the clock edge that takes it. An event pulse is counted at the edge that ends its cycle, and an overflow status bit sets on that same edge. `irq_o` follows one edge after the status bit, or after the mode and enable become valid. After a control write, the active flag is low for at least one cycle. The bench drives inputs at the falling edge and samples at the following falling edge, so that each result is read exactly as many edges after its cause as these latencies give. It checks both sides of the interrupt timing: the cycle before `irq_o` rises and the cycle after.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CTR   = 10;
  localparam int CTR_W     = 48;
  localparam int EVT_W     = 8;
  localparam int REG_W     = 64;
  localparam int ADDR_W    = 5;
  localparam int LO_GROUP  = 8;
  localparam int FIXED_CTR = 2;

  // control register layout
  localparam int CTL_EN_LO    = 0;
  localparam int CTL_MODE_LSB = 8;
  localparam int MODE_W       = 3;
  localparam int CTL_ACT_BIT  = 11;
  localparam int CTL_IE_LO    = 12;
  localparam int CTL_EN_HI    = 32;
  localparam int CTL_IE_HI    = 44;

  // filter register layout
  localparam int FLT_U_LO = 0;
  localparam int FLT_K_LO = 8;
  localparam int FLT_U_HI = 16;
  localparam int FLT_K_HI = 18;

  localparam logic [ADDR_W-1:0] A_CTL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_FLT  = 5'd1;
  localparam logic [ADDR_W-1:0] A_ES0  = 5'd2;
  localparam logic [ADDR_W-1:0] A_ES1  = 5'd3;
  localparam logic [ADDR_W-1:0] A_OVF  = 5'd4;
  localparam int                A_CTR0 = 8;

  typedef enum logic [MODE_W-1:0] {
    IM_OFF  = 3'd0,
    IM_FAST = 3'd1
  } irq_mode_e;

  function automatic int grp_pos(int i, int lo_base, int hi_base);
    return (i < LO_GROUP) ? lo_base + i : hi_base + (i - LO_GROUP);
  endfunction

  function automatic int ctl_en_pos(int i);
    return grp_pos(i, CTL_EN_LO, CTL_EN_HI);
  endfunction

  function automatic int ctl_ie_pos(int i);
    return grp_pos(i, CTL_IE_LO, CTL_IE_HI);
  endfunction

  function automatic int flt_u_pos(int i);
    return grp_pos(i, FLT_U_LO, FLT_U_HI);
  endfunction

  function automatic int flt_k_pos(int i);
    return grp_pos(i, FLT_K_LO, FLT_K_HI);
  endfunction

  function automatic logic [REG_W-1:0] ctl_wmask(int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m[ctl_en_pos(i)] = 1'b1;
      m[ctl_ie_pos(i)] = 1'b1;
    end
    m[CTL_MODE_LSB +: MODE_W] = '1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] flt_wmask(int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m[flt_u_pos(i)] = 1'b1;
      m[flt_k_pos(i)] = 1'b1;
    end
    return m;
  endfunction

  // a counter reaches its top bit only when every lower bit was set
  function automatic logic crosses_top(logic [CTR_W-1:0] cur);
    return (cur[CTR_W-1] == 1'b0) && (&cur[CTR_W-2:0]);
  endfunction
endpackage

// File: rtl/pmu_regs.sv
module pmu_regs
  import pmu_pkg::*;
#(
  parameter int NUM   = NUM_CTR,
  parameter int EW    = EVT_W,
  localparam int NPROG = NUM - FIXED_CTR,
  localparam int ES_W  = 4 * EW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  output logic [REG_W-1:0]         ctl_q,
  output logic [REG_W-1:0]         flt_q,
  output logic [ES_W-1:0]          es0_q,
  output logic [ES_W-1:0]          es1_q,
  output logic                     ctl_wr,
  output logic                     ovf_clr_wr,
  output logic [NUM-1:0]           ctr_wr,
  output logic [NUM-1:0]           ctr_en,
  output logic [NUM-1:0]           irq_en,
  output logic [NUM-1:0]           usr_ok,
  output logic [NUM-1:0]           krn_ok,
  output logic [NPROG-1:0][EW-1:0] evsel,
  output logic [MODE_W-1:0]        mode
);
  localparam logic [REG_W-1:0] CTL_MASK = ctl_wmask(NUM);
  localparam logic [REG_W-1:0] FLT_MASK = flt_wmask(NUM);

  assign ctl_wr     = wr_en && (wr_addr == A_CTL);
  assign ovf_clr_wr = wr_en && (wr_addr == A_OVF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      flt_q <= '0;
      es0_q <= '0;
      es1_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTL:   ctl_q <= wr_data & CTL_MASK;
        A_FLT:   flt_q <= wr_data & FLT_MASK;
        A_ES0:   es0_q <= wr_data[ES_W-1:0];
        A_ES1:   es1_q <= wr_data[ES_W-1:0];
        default: ;
      endcase
    end
  end

  assign mode = ctl_q[CTL_MODE_LSB +: MODE_W];

  for (genvar g = 0; g < NUM; g++) begin : g_dec
    assign ctr_wr[g] = wr_en && (wr_addr == ADDR_W'(A_CTR0 + g));
    assign ctr_en[g] = ctl_q[ctl_en_pos(g)];
    assign irq_en[g] = ctl_q[ctl_ie_pos(g)];
    assign usr_ok[g] = flt_q[flt_u_pos(g)];
    assign krn_ok[g] = flt_q[flt_k_pos(g)];
  end

  for (genvar p = 0; p < NPROG; p++) begin : g_sel
    if (p < 4) begin : g_lo
      assign evsel[p] = es0_q[p*EW +: EW];
    end else begin : g_hi
      assign evsel[p] = es1_q[(p-4)*EW +: EW];
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int W = CTR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         usr_ok,
  input  logic         krn_ok,
  input  logic         in_kernel,
  input  logic         evt_hit,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] value,
  output logic         ovf_evt
);
  logic qual;
  logic inc;

  assign qual    = in_kernel ? krn_ok : usr_ok;
  assign inc     = count_en && qual && evt_hit;
  assign ovf_evt = inc && !sw_wr && crosses_top(value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (sw_wr)  value <= sw_data;
    else if (inc)    value <= value + 1'b1;
  end

  // R6: software load wins over a same-cycle increment
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (value == $past(sw_data)));

  // R5: no load and no qualified event means no change
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !inc) |=> $stable(value));

  // R7: one step per qualified event, modulo 2^W
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !sw_wr) |=> (value == W'($past(value) + 1'b1)));

  // R8: an overflow event leaves the top bit set
  a_r8_top_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> value[W-1]);
endmodule

// File: rtl/pmu_irq.sv
module pmu_irq
  import pmu_pkg::*;
#(
  parameter int NUM = NUM_CTR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM-1:0]    ovf_evt,
  input  logic              clr_wr,
  input  logic [NUM-1:0]    clr_bits,
  input  logic              ctl_wr,
  input  logic [MODE_W-1:0] mode,
  input  logic [NUM-1:0]    irq_en,
  output logic [NUM-1:0]    ovf_q,
  output logic              active
);
  logic [NUM-1:0] clr_mask;
  logic           req;

  assign clr_mask = clr_wr ? clr_bits : '0;
  assign req      = (mode != MODE_W'(IM_OFF)) && (|(ovf_q & irq_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~clr_mask) | ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active <= 1'b0;
    else if (ctl_wr) active <= 1'b0;
    else if (req)    active <= 1'b1;
  end

  // R8: an overflow event is recorded in status on the same edge
  a_r8_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_evt) |=> ((ovf_q & $past(ovf_evt)) == $past(ovf_evt)));

  // R9: write-one-to-clear drops the bits written, unless set again
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((ovf_q & $past(clr_mask & ~ovf_evt)) == '0));

  // R10: the flag only rises with the mode on and an enabled overflow pending
  a_r10_raise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past((mode != '0) && (|(ovf_q & irq_en))));

  // R11: a control write always leaves the flag low
  a_r11_ctl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !active);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_C = NUM_CTR,
  parameter int CW    = CTR_W,
  parameter int EW    = EVT_W,
  localparam int NUM_EVT = 1 << EW,
  localparam int NPROG   = NUM_C - FIXED_CTR,
  localparam int ES_W    = 4 * EW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] ev_pulse,
  input  logic               instr_ret,
  input  logic               priv_kernel,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq_o
);
  logic [REG_W-1:0]          ctl_q, flt_q;
  logic [ES_W-1:0]           es0_q, es1_q;
  logic                      ctl_wr, ovf_clr_wr;
  logic [NUM_C-1:0]          ctr_wr, ctr_en, irq_en, usr_ok, krn_ok;
  logic [NPROG-1:0][EW-1:0]  evsel;
  logic [MODE_W-1:0]         mode;
  logic [NUM_C-1:0]          ovf_evt, ovf_q;
  logic                      active;
  logic [NUM_C-1:0][CW-1:0]  cnt;

  pmu_regs #(.NUM(NUM_C), .EW(EW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctl_q      (ctl_q),
    .flt_q      (flt_q),
    .es0_q      (es0_q),
    .es1_q      (es1_q),
    .ctl_wr     (ctl_wr),
    .ovf_clr_wr (ovf_clr_wr),
    .ctr_wr     (ctr_wr),
    .ctr_en     (ctr_en),
    .irq_en     (irq_en),
    .usr_ok     (usr_ok),
    .krn_ok     (krn_ok),
    .evsel      (evsel),
    .mode       (mode)
  );

  for (genvar g = 0; g < NUM_C; g++) begin : g_ctr
    logic hit;
    if (g == 0) begin : g_cyc
      assign hit = 1'b1;
    end else if (g == 1) begin : g_ins
      assign hit = instr_ret;
    end else begin : g_prog
      assign hit = ev_pulse[evsel[g-FIXED_CTR]];
    end

    pmu_counter #(.W(CW)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (ctr_en[g]),
      .usr_ok    (usr_ok[g]),
      .krn_ok    (krn_ok[g]),
      .in_kernel (priv_kernel),
      .evt_hit   (hit),
      .sw_wr     (ctr_wr[g]),
      .sw_data   (wr_data[CW-1:0]),
      .value     (cnt[g]),
      .ovf_evt   (ovf_evt[g])
    );
  end

  pmu_irq #(.NUM(NUM_C)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_evt  (ovf_evt),
    .clr_wr   (ovf_clr_wr),
    .clr_bits (wr_data[NUM_C-1:0]),
    .ctl_wr   (ctl_wr),
    .mode     (mode),
    .irq_en   (irq_en),
    .ovf_q    (ovf_q),
    .active   (active)
  );

  assign irq_o = active;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTL: rd_data = ctl_q | (REG_W'(active) << CTL_ACT_BIT);
      A_FLT: rd_data = flt_q;
      A_ES0: rd_data = REG_W'(es0_q);
      A_ES1: rd_data = REG_W'(es1_q);
      A_OVF: rd_data = REG_W'(ovf_q);
      default: begin
        for (int i = 0; i < NUM_C; i++) begin
          if (rd_addr == ADDR_W'(A_CTR0 + i)) rd_data = REG_W'(cnt[i]);
        end
      end
    endcase
  end

  // R1: the interrupt output is low while in reset and right after it
  a_r1_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [255:0] ev_pulse = '0;
  logic        instr_ret = 1'b0;
  logic        priv_kernel = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        irq_o;

  int tests = 0;
  int fails = 0;

  perf_mon_unit u_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .instr_ret(instr_ret),
    .priv_kernel(priv_kernel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bit positions restated from the requirements
  function automatic logic [63:0] b_en(int n);  return 64'd1 << ((n < 8) ? n : n + 24); endfunction
  function automatic logic [63:0] b_ie(int n);  return 64'd1 << ((n < 8) ? n + 12 : n + 36); endfunction
  function automatic logic [63:0] b_usr(int n); return 64'd1 << ((n < 8) ? n : n + 8); endfunction
  function automatic logic [63:0] b_krn(int n); return 64'd1 << ((n < 8) ? n + 8 : n + 10); endfunction
  function automatic logic [7:0]  code_of(int n); return 8'(8'h30 + 17 * n); endfunction
  localparam logic [63:0] MODE_ON = 64'h100;
  localparam logic [63:0] ACT_BIT = 64'h800;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    rd_addr = 5'(a);
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input int code);
    ev_pulse[code] = 1'b1;
    @(negedge clk);
    ev_pulse[code] = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] es0, es1, flt_all_k, en_prog;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      if (a < 5 || a >= 8) begin
        rd(a, v); chk($sformatf("R1 reset addr %0d", a), v, 64'd0);
      end
    end
    chk("R1 irq after reset", 64'(irq_o), 64'd0);

    // R2 counter 0 counts cycles (user-only qualifier, gated by privilege)
    priv_kernel = 1'b1;
    wr(1, b_usr(0));
    wr(0, b_en(0));
    wr(8, 64'd0);
    priv_kernel = 1'b0;
    idle(13);
    priv_kernel = 1'b1;
    idle(2);
    rd(8, v); chk("R2 cycle counter", v, 64'd13);

    // R2/R4 counter 1 counts instruction pulses in kernel only
    wr(1, b_krn(1));
    wr(0, b_en(1));
    for (int k = 0; k < 7; k++) begin
      if (k % 2 == 1) begin instr_ret = 1'b1; @(negedge clk); instr_ret = 1'b0; end
      else @(negedge clk);
    end
    priv_kernel = 1'b0;
    instr_ret = 1'b1; @(negedge clk); instr_ret = 1'b0;
    priv_kernel = 1'b1;
    rd(9, v); chk("R2 instruction counter", v, 64'd3);
    rd(8, v); chk("R5 disabled cycle counter holds", v, 64'd13);

    // R3 sweep every event code on counter 2
    wr(1, b_krn(2));
    wr(0, b_en(2));
    for (int k = 0; k < 256; k++) begin
      wr(2, 64'(k));
      wr(10, 64'd0);
      for (int p = 0; p <= k % 4; p++) pulse(k);
      pulse((k + 1) % 256);
      rd(10, v); chk($sformatf("R3 code %0d on counter 2", k), v, 64'(k % 4 + 1));
    end

    // R3 byte placement for counters 2..9
    es0 = '0; es1 = '0; flt_all_k = '0; en_prog = '0;
    for (int n = 2; n < 10; n++) begin
      if (n < 6) es0 |= 64'(code_of(n)) << ((n - 2) * 8);
      else       es1 |= 64'(code_of(n)) << ((n - 6) * 8);
      flt_all_k |= b_krn(n);
      en_prog   |= b_en(n);
    end
    wr(2, es0); wr(3, es1); wr(1, flt_all_k); wr(0, en_prog);
    for (int n = 2; n < 10; n++) wr(8 + n, 64'd0);
    for (int n = 2; n < 10; n++) for (int p = 0; p < n - 1; p++) pulse(code_of(n));
    for (int n = 2; n < 10; n++) begin
      rd(8 + n, v); chk($sformatf("R3 placement counter %0d", n), v, 64'(n - 1));
    end

    // R4 qualifier sweep on counter 8
    for (int u = 0; u < 2; u++) for (int kq = 0; kq < 2; kq++) for (int pk = 0; pk < 2; pk++) begin
      wr(1, (u != 0 ? b_usr(8) : 64'd0) | (kq != 0 ? b_krn(8) : 64'd0));
      wr(16, 64'd0);
      priv_kernel = (pk != 0);
      pulse(code_of(8)); pulse(code_of(8));
      priv_kernel = 1'b1;
      rd(16, v);
      chk($sformatf("R4 user=%0d kernel=%0d priv=%0d", u, kq, pk), v,
          (((pk != 0) ? kq : u) != 0) ? 64'd2 : 64'd0);
    end

    // R5 disabled counter 9 holds
    wr(1, flt_all_k);
    wr(0, en_prog & ~b_en(9));
    pulse(code_of(9)); pulse(code_of(9)); pulse(code_of(9));
    rd(17, v); chk("R5 disabled counter 9 holds", v, 64'd8);

    // R6 write beats a same-cycle increment
    wr(1, b_usr(0));
    wr(0, b_en(0));
    priv_kernel = 1'b0;
    wr(8, 64'h1234_5678_9ABC);
    rd(8, v); chk("R6 write wins over increment", v, 64'h1234_5678_9ABC);
    @(negedge clk);
    rd(8, v); chk("R6 counting resumes after write", v, 64'h1234_5678_9ABD);
    priv_kernel = 1'b1;

    // R7 wrap, R8 overflow set
    wr(1, flt_all_k);
    wr(0, b_en(3));
    wr(11, 64'hFFFF_FFFF_FFFF);
    pulse(code_of(3));
    rd(11, v); chk("R7 wrap to zero", v, 64'd0);
    rd(4, v);  chk("R7 wrap sets no status", v, 64'd0);
    wr(11, 64'h7FFF_FFFF_FFFF);
    pulse(code_of(3));
    rd(11, v); chk("R8 counter reaches bit 47", v, 64'h8000_0000_0000);
    rd(4, v);  chk("R8 status bit 3 set", v, 64'h8);
    chk("R10 no irq while mode off", 64'(irq_o), 64'd0);
    pulse(code_of(3));
    rd(4, v);  chk("R8 status sticky", v, 64'h8);

    // R10 mode off keeps irq low even with enable
    wr(0, b_en(3) | b_ie(3));
    idle(2);
    chk("R10 mode off, irq low", 64'(irq_o), 64'd0);
    wr(0, b_en(3) | b_ie(3) | MODE_ON);
    chk("R10 irq not yet up", 64'(irq_o), 64'd0);
    @(negedge clk);
    chk("R10 irq up one edge later", 64'(irq_o), 64'd1);
    rd(0, v); chk("R10 active flag readable", v, b_en(3) | b_ie(3) | MODE_ON | ACT_BIT);

    // R11 control write clears, relatches while pending
    wr(0, b_en(3) | b_ie(3) | MODE_ON);
    chk("R11 cleared by control write", 64'(irq_o), 64'd0);
    @(negedge clk);
    chk("R11 relatches while pending", 64'(irq_o), 64'd1);

    // R9 write-one-to-clear
    wr(4, 64'h0);
    rd(4, v); chk("R9 writing zero keeps status", v, 64'h8);
    wr(4, 64'h8);
    rd(4, v); chk("R9 status cleared", v, 64'h0);
    chk("R11 flag held until control write", 64'(irq_o), 64'd1);
    wr(0, b_en(3) | b_ie(3) | MODE_ON);
    chk("R11 dropped with no overflow", 64'(irq_o), 64'd0);
    idle(2);
    chk("R11 stays dropped", 64'(irq_o), 64'd0);

    // R10 interrupt enable gating on counter 9
    wr(0, b_en(9) | MODE_ON);
    wr(17, 64'h7FFF_FFFF_FFFF);
    pulse(code_of(9));
    rd(4, v); chk("R8 status bit 9 set", v, 64'h200);
    idle(2);
    chk("R10 irq low without enable", 64'(irq_o), 64'd0);
    wr(0, b_en(9) | b_ie(9) | MODE_ON);
    chk("R10 counter 9 irq not yet up", 64'(irq_o), 64'd0);
    @(negedge clk);
    chk("R10 counter 9 irq up", 64'(irq_o), 64'd1);
    wr(4, 64'h200);
    wr(0, 64'd0);
    idle(1);
    chk("R11 final drop", 64'(irq_o), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule